// File: doc/BRIEF.md
# Floating-Point Exception Trap Mode Controller

This block sits beside a small pipelined floating-point unit and decides what happens when an operation finishes with exception flags raised. Each of the five exception classes has a two-bit mode. In nonstop mode the class only updates status flags. In the imprecise trap mode a trap is requested, but the reported PC need not be the faulting one. In the precise (restartable) mode a trap is requested that names the faulting operation's PC, so a handler can repair the operands and run that operation again.

The controller tracks up to `DEPTH` issued but unfinished operations, tagged with their PCs, in issue order. Completions retire the oldest one. Two kinds of flags are kept: accumulating status flags that only an explicit write can clear, and the flags of the most recent completion. Precise mode trades throughput for exactness: while any class is in that mode, a new operation may not issue until the older one has finished. A sync request holds the program counter until the unit is empty and does nothing else. A branch query on one flag of the most recent completion waits in the same way before it resolves.

Top module: `fp_trap_ctl`

## Requirements
- R1: After reset the status and last-op flags are zero, no trap is requested, every class is in nonstop mode and `issue_ready` is high.
- R2: Flag bit positions are [4] invalid, [3] divide-by-zero, [2] overflow, [1] underflow, [0] inexact. The mode of class i is `ctl_wr_mode[2i+1:2i]`, with 00 nonstop, 01 imprecise trap, 10 precise trap and 11 also precise. A completion whose raised classes are all nonstop requests no trap.
- R3: The status flags OR in each completion's flags and keep them. Only a status write changes them otherwise. A status write and a completion in the same cycle give the written value ORed with the completion's flags.
- R4: The last-op flags take the flags of every completion, zero flags included, one cycle after the completion.
- R5: When a completion raises a class in imprecise mode and no raised class is in precise mode, the cycle after the completion shows `trap_valid` high, `trap_precise` low, `trap_flags` equal to the raised classes whose mode is not nonstop, and `trap_pc` equal to the PC of the most recently issued operation.
- R6: When any raised class is in precise mode (10 or 11), the trap shows `trap_precise` high and `trap_pc` equal to the completing (oldest outstanding) operation's PC. Any imprecise classes raised at the same time are still listed in `trap_flags`.
- R7: While any class is in precise mode and an operation is outstanding, `issue_ready` is low. In nonstop or imprecise modes issue stalls only when `DEPTH` operations are outstanding.
- R8: While `sync_req` is high and an operation is outstanding, `pc_hold` is high and `issue_ready` is low. With nothing outstanding, `pc_hold` is low. A sync changes no flag.
- R9: While `br_req` is high and an operation is outstanding, `br_wait` is high and `br_taken` is low. With nothing outstanding, `br_taken` equals bit `br_sel` of the last-op flags.
- R10: A completion that arrives while nothing is outstanding is ignored: flags are unchanged and no trap is requested.
- R11: A trap request lasts exactly one cycle per trapping completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Write the mode register |
| ctl_wr_mode | input | 10 | Two mode bits per exception class |
| sticky_wr_en | input | 1 | Write the status flags |
| sticky_wr_data | input | 5 | Value written to the status flags |
| issue_valid | input | 1 | An FP operation is offered for issue |
| issue_pc | input | 32 | PC of the offered operation |
| issue_ready | output | 1 | Offered operation is accepted this cycle |
| cmpl_valid | input | 1 | The oldest outstanding operation completes |
| cmpl_flags | input | 5 | Exception flags of the completing operation |
| sync_req | input | 1 | Synchronization request |
| pc_hold | output | 1 | PC must not advance |
| br_req | input | 1 | Branch-on-exception query |
| br_sel | input | 3 | Flag bit tested by the query |
| br_wait | output | 1 | Query not yet resolvable |
| br_taken | output | 1 | Query resolved as taken |
| sticky_flags | output | 5 | Accumulated status flags |
| last_flags | output | 5 | Flags of the most recent completion |
| trap_valid | output | 1 | One-cycle trap request |
| trap_flags | output | 5 | Classes that caused the trap |
| trap_precise | output | 1 | Trap is restartable and the PC is exact |
| trap_pc | output | 32 | Reported PC |

## Verification
Two same-cycle collisions are provoked on purpose. In the first, a status-flag write is driven on the same edge as a completion with different flags. The status flags must then hold the OR of both, so neither source is lost. In the second, one completion raises one class in imprecise mode and another in precise mode. The trap must report the faulting operation's PC and be marked precise, while the imprecise class still appears in the trap flags.

// File: rtl/fp_trap_pkg.sv
package fp_trap_pkg;

    localparam int NUM_EXC = 5;

    localparam int EXC_INEXACT   = 0;
    localparam int EXC_UNDERFLOW = 1;
    localparam int EXC_OVERFLOW  = 2;
    localparam int EXC_DIVZERO   = 3;
    localparam int EXC_INVALID   = 4;

    typedef logic [NUM_EXC-1:0] exc_vec_t;

    typedef enum logic [1:0] {
        MODE_NONSTOP  = 2'b00,
        MODE_IMPRECISE = 2'b01,
        MODE_PRECISE  = 2'b10,
        MODE_PRECISE2 = 2'b11
    } trap_mode_e;

    // Class traps at all when its mode is not nonstop.
    function automatic logic mode_traps(input trap_mode_e m);
        return m != MODE_NONSTOP;
    endfunction

    // Both upper encodings ask for a restartable trap.
    function automatic logic mode_precise(input trap_mode_e m);
        return (m == MODE_PRECISE) || (m == MODE_PRECISE2);
    endfunction

endpackage

// File: rtl/fp_inflight_q.sv
module fp_inflight_q #(
    parameter int DEPTH = 4,
    parameter int PC_W  = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [PC_W-1:0]  push_pc,
    input  logic             pop,
    output logic [PC_W-1:0]  head_pc,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [PC_W-1:0]  slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign head_pc = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_pc;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fp_flag_regs.sv
module fp_flag_regs
    import fp_trap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmpl_fire,
    input  exc_vec_t cmpl_flags,
    input  logic     wr_en,
    input  exc_vec_t wr_data,
    output exc_vec_t sticky,
    output exc_vec_t last
);
    exc_vec_t sticky_base;
    exc_vec_t sticky_add;

    always_comb begin
        sticky_base = wr_en ? wr_data : sticky;
        sticky_add  = cmpl_fire ? cmpl_flags : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky <= '0;
            last   <= '0;
        end else begin
            sticky <= sticky_base | sticky_add;
            if (cmpl_fire) begin
                last <= cmpl_flags;
            end
        end
    end
endmodule

// File: rtl/fp_trap_gen.sv
module fp_trap_gen
    import fp_trap_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmpl_fire,
    input  exc_vec_t        cmpl_flags,
    input  exc_vec_t        trap_mask,
    input  exc_vec_t        precise_mask,
    input  logic [PC_W-1:0] fault_pc,
    input  logic [PC_W-1:0] youngest_pc,
    output logic            trap_valid,
    output exc_vec_t        trap_flags,
    output logic            trap_precise,
    output logic [PC_W-1:0] trap_pc
);
    exc_vec_t hit;
    logic     want_precise;

    always_comb begin
        hit          = cmpl_flags & trap_mask;
        want_precise = |(cmpl_flags & precise_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_valid   <= 1'b0;
            trap_flags   <= '0;
            trap_precise <= 1'b0;
            trap_pc      <= '0;
        end else begin
            trap_valid <= cmpl_fire && (hit != '0);
            if (cmpl_fire && (hit != '0)) begin
                trap_flags   <= hit;
                trap_precise <= want_precise;
                trap_pc      <= want_precise ? fault_pc : youngest_pc;
            end
        end
    end
endmodule

// File: rtl/fp_trap_ctl.sv
module fp_trap_ctl
    import fp_trap_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PC_W  = 32,
    parameter int SEL_W = 3,
    localparam int MODE_W = 2 * NUM_EXC,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr_en,
    input  logic [MODE_W-1:0] ctl_wr_mode,
    input  logic              sticky_wr_en,
    input  logic [NUM_EXC-1:0] sticky_wr_data,
    input  logic              issue_valid,
    input  logic [PC_W-1:0]   issue_pc,
    output logic              issue_ready,
    input  logic              cmpl_valid,
    input  logic [NUM_EXC-1:0] cmpl_flags,
    input  logic              sync_req,
    output logic              pc_hold,
    input  logic              br_req,
    input  logic [SEL_W-1:0]  br_sel,
    output logic              br_wait,
    output logic              br_taken,
    output logic [NUM_EXC-1:0] sticky_flags,
    output logic [NUM_EXC-1:0] last_flags,
    output logic              trap_valid,
    output logic [NUM_EXC-1:0] trap_flags,
    output logic              trap_precise,
    output logic [PC_W-1:0]   trap_pc
);
    trap_mode_e       class_mode [NUM_EXC];
    exc_vec_t         trap_mask;
    exc_vec_t         precise_mask;
    logic             precise_any;
    logic [PC_W-1:0]  youngest_pc;
    logic [PC_W-1:0]  head_pc;
    logic [CNT_W-1:0] inflight_cnt;
    logic             q_full;
    logic             q_empty;
    logic             issue_fire;
    logic             cmpl_fire;
    logic             sel_bit;

    // Per-class mode register and mask decode.
    for (genvar i = 0; i < NUM_EXC; i++) begin : g_class
        always_ff @(posedge clk) begin
            if (rst) begin
                class_mode[i] <= MODE_NONSTOP;
            end else if (ctl_wr_en) begin
                class_mode[i] <= trap_mode_e'(ctl_wr_mode[2*i +: 2]);
            end
        end
        assign trap_mask[i]    = mode_traps(class_mode[i]);
        assign precise_mask[i] = mode_precise(class_mode[i]);
    end

    assign precise_any = |precise_mask;

    // Issue gating: depth, precise serialization, sync hold.
    always_comb begin
        pc_hold     = sync_req && !q_empty;
        issue_ready = !q_full && !(precise_any && !q_empty) && !pc_hold;
        issue_fire  = issue_valid && issue_ready;
        cmpl_fire   = cmpl_valid && !q_empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            youngest_pc <= '0;
        end else if (issue_fire) begin
            youngest_pc <= issue_pc;
        end
    end

    // Branch-on-exception query.
    always_comb begin
        sel_bit = 1'b0;
        for (int i = 0; i < NUM_EXC; i++) begin
            if (br_sel == SEL_W'(i)) begin
                sel_bit = last_flags[i];
            end
        end
        br_wait  = br_req && !q_empty;
        br_taken = br_req && q_empty && sel_bit;
    end

    fp_inflight_q #(
        .DEPTH (DEPTH),
        .PC_W  (PC_W)
    ) u_queue (
        .clk     (clk),
        .rst     (rst),
        .push    (issue_fire),
        .push_pc (issue_pc),
        .pop     (cmpl_fire),
        .head_pc (head_pc),
        .count   (inflight_cnt),
        .full    (q_full),
        .empty   (q_empty)
    );

    fp_flag_regs u_flags (
        .clk        (clk),
        .rst        (rst),
        .cmpl_fire  (cmpl_fire),
        .cmpl_flags (cmpl_flags),
        .wr_en      (sticky_wr_en),
        .wr_data    (sticky_wr_data),
        .sticky     (sticky_flags),
        .last       (last_flags)
    );

    fp_trap_gen #(
        .PC_W (PC_W)
    ) u_trap (
        .clk          (clk),
        .rst          (rst),
        .cmpl_fire    (cmpl_fire),
        .cmpl_flags   (cmpl_flags),
        .trap_mask    (trap_mask),
        .precise_mask (precise_mask),
        .fault_pc     (head_pc),
        .youngest_pc  (youngest_pc),
        .trap_valid   (trap_valid),
        .trap_flags   (trap_flags),
        .trap_precise (trap_precise),
        .trap_pc      (trap_pc)
    );
endmodule

// File: rtl/fp_trap_ctl_chk.sv
module fp_trap_ctl_chk
    import fp_trap_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PC_W  = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               issue_ready,
    input logic               sync_req,
    input logic               pc_hold,
    input logic               br_wait,
    input logic               br_taken,
    input logic               cmpl_valid,
    input logic               sticky_wr_en,
    input logic [NUM_EXC-1:0] sticky_flags,
    input logic               trap_valid,
    input logic               trap_precise,
    input logic [PC_W-1:0]    trap_pc,
    input logic [PC_W-1:0]    head_pc,
    input logic [CNT_W-1:0]   inflight_cnt,
    input logic               precise_any
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R7: never more outstanding operations than the queue holds
    a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
        inflight_cnt <= CNT_W'(DEPTH));

    // R7: precise mode serializes issue
    a_r7_precise_serial: assert property (@(posedge clk) disable iff (rst)
        (precise_any && inflight_cnt != '0) |-> !issue_ready);

    // R8: an active sync blocks issue
    a_r8_sync_blocks_issue: assert property (@(posedge clk) disable iff (rst)
        pc_hold |-> (sync_req && !issue_ready));

    // R9: a query cannot be taken while it still waits
    a_r9_taken_not_waiting: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> !br_wait);

    // R3: status bits never drop without a write
    a_r3_sticky_keeps: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(sticky_wr_en)) |->
            ((sticky_flags & $past(sticky_flags)) == $past(sticky_flags)));

    // R10: a trap follows only a completion that had an outstanding op
    a_r10_trap_has_source: assert property (@(posedge clk) disable iff (rst)
        (past_ok && trap_valid) |->
            ($past(cmpl_valid) && $past(inflight_cnt) != '0));

    // R6: a precise trap names the faulting op's PC
    a_r6_precise_pc: assert property (@(posedge clk) disable iff (rst)
        (past_ok && trap_valid && trap_precise) |-> (trap_pc == $past(head_pc)));
endmodule

bind fp_trap_ctl fp_trap_ctl_chk #(
    .DEPTH (DEPTH),
    .PC_W  (PC_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .issue_ready  (issue_ready),
    .sync_req     (sync_req),
    .pc_hold      (pc_hold),
    .br_wait      (br_wait),
    .br_taken     (br_taken),
    .cmpl_valid   (cmpl_valid),
    .sticky_wr_en (sticky_wr_en),
    .sticky_flags (sticky_flags),
    .trap_valid   (trap_valid),
    .trap_precise (trap_precise),
    .trap_pc      (trap_pc),
    .head_pc      (head_pc),
    .inflight_cnt (inflight_cnt),
    .precise_any  (precise_any)
);

// File: tb/tb_fp_trap_ctl.sv
`timescale 1ns/1ps
module tb_fp_trap_ctl;
    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_wr_en;
    logic [9:0]  ctl_wr_mode;
    logic        sticky_wr_en;
    logic [4:0]  sticky_wr_data;
    logic        issue_valid;
    logic [31:0] issue_pc;
    logic        issue_ready;
    logic        cmpl_valid;
    logic [4:0]  cmpl_flags;
    logic        sync_req;
    logic        pc_hold;
    logic        br_req;
    logic [2:0]  br_sel;
    logic        br_wait;
    logic        br_taken;
    logic [4:0]  sticky_flags;
    logic [4:0]  last_flags;
    logic        trap_valid;
    logic [4:0]  trap_flags;
    logic        trap_precise;
    logic [31:0] trap_pc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    fp_trap_ctl dut (
        .clk(clk), .rst(rst),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_mode(ctl_wr_mode),
        .sticky_wr_en(sticky_wr_en), .sticky_wr_data(sticky_wr_data),
        .issue_valid(issue_valid), .issue_pc(issue_pc), .issue_ready(issue_ready),
        .cmpl_valid(cmpl_valid), .cmpl_flags(cmpl_flags),
        .sync_req(sync_req), .pc_hold(pc_hold),
        .br_req(br_req), .br_sel(br_sel), .br_wait(br_wait), .br_taken(br_taken),
        .sticky_flags(sticky_flags), .last_flags(last_flags),
        .trap_valid(trap_valid), .trap_flags(trap_flags),
        .trap_precise(trap_precise), .trap_pc(trap_pc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // All drivers change at the falling edge; registered results are read
    // at the falling edge after the rising edge that captured them.
    task automatic set_mode(input logic [9:0] m);
        ctl_wr_en = 1'b1; ctl_wr_mode = m;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic write_sticky(input logic [4:0] v);
        sticky_wr_en = 1'b1; sticky_wr_data = v;
        @(negedge clk);
        sticky_wr_en = 1'b0;
    endtask

    task automatic do_issue(input logic [31:0] pc);
        issue_valid = 1'b1; issue_pc = pc;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic do_cmpl(input logic [4:0] f);
        cmpl_valid = 1'b1; cmpl_flags = f;
        @(negedge clk);
        cmpl_valid = 1'b0; cmpl_flags = '0;
    endtask

    task automatic t_reset();
        chk("R1", "sticky", 32'(sticky_flags), 0);
        chk("R1", "last", 32'(last_flags), 0);
        chk("R1", "trap_valid", 32'(trap_valid), 0);
        chk("R1", "issue_ready", 32'(issue_ready), 1);
    endtask

    task automatic t_nonstop();
        do_issue(32'h10);
        do_cmpl(5'b00101);
        chk("R2", "no trap in nonstop", 32'(trap_valid), 0);
        chk("R3", "sticky first", 32'(sticky_flags), 32'h05);
        chk("R4", "last first", 32'(last_flags), 32'h05);
        do_issue(32'h14);
        do_cmpl(5'b00010);
        chk("R3", "sticky accumulates", 32'(sticky_flags), 32'h07);
        chk("R4", "last overwritten", 32'(last_flags), 32'h02);
        do_issue(32'h18);
        do_cmpl(5'b00000);
        chk("R4", "last zero", 32'(last_flags), 32'h00);
        chk("R3", "sticky kept", 32'(sticky_flags), 32'h07);
    endtask

    task automatic t_sticky_write();
        write_sticky(5'b00000);
        chk("R3", "sticky cleared by write", 32'(sticky_flags), 0);
        do_issue(32'h20);
        sticky_wr_en = 1'b1; sticky_wr_data = 5'b00001;
        cmpl_valid = 1'b1; cmpl_flags = 5'b01000;
        @(negedge clk);
        sticky_wr_en = 1'b0; cmpl_valid = 1'b0; cmpl_flags = '0;
        chk("R3", "write and completion merge", 32'(sticky_flags), 32'h09);
        write_sticky(5'b00000);
    endtask

    task automatic t_imprecise();
        set_mode(10'b01_00_00_00_00);
        do_issue(32'h100);
        do_issue(32'h104);
        chk("R7", "imprecise mode does not stall", 32'(issue_ready), 1);
        do_issue(32'h108);
        do_cmpl(5'b10001);
        chk("R5", "trap_valid", 32'(trap_valid), 1);
        chk("R5", "trap_flags", 32'(trap_flags), 32'h10);
        chk("R5", "trap_pc youngest", trap_pc, 32'h108);
        chk("R5", "trap_precise", 32'(trap_precise), 0);
        @(negedge clk);
        chk("R11", "trap one cycle", 32'(trap_valid), 0);
        do_cmpl(5'b00000);
        do_cmpl(5'b00000);
        chk("R5", "no trap on clean op", 32'(trap_valid), 0);
    endtask

    task automatic t_precise();
        set_mode(10'b00_00_10_00_00);
        do_issue(32'h200);
        chk("R7", "precise mode serializes", 32'(issue_ready), 0);
        sync_req = 1'b1;
        #1;
        chk("R8", "sync holds while busy", 32'(pc_hold), 1);
        sync_req = 1'b0;
        do_issue(32'h204);
        do_cmpl(5'b00100);
        chk("R6", "trap_valid", 32'(trap_valid), 1);
        chk("R6", "trap_pc faulting", trap_pc, 32'h200);
        chk("R6", "trap_precise", 32'(trap_precise), 1);
        chk("R6", "trap_flags", 32'(trap_flags), 32'h04);
        chk("R7", "ready after drain", 32'(issue_ready), 1);
        write_sticky(5'b00000);
    endtask

    task automatic t_mixed();
        set_mode(10'b01_11_00_00_00);
        do_issue(32'h300);
        chk("R7", "mode 11 serializes", 32'(issue_ready), 0);
        do_cmpl(5'b11000);
        chk("R6", "mixed trap_valid", 32'(trap_valid), 1);
        chk("R6", "mixed precise wins", 32'(trap_precise), 1);
        chk("R6", "mixed pc", trap_pc, 32'h300);
        chk("R6", "mixed flags", 32'(trap_flags), 32'h18);
    endtask

    task automatic t_spurious();
        logic [4:0] s0;
        logic [4:0] l0;
        s0 = sticky_flags; l0 = last_flags;
        do_cmpl(5'b11111);
        chk("R10", "no trap", 32'(trap_valid), 0);
        chk("R10", "sticky unchanged", 32'(sticky_flags), 32'(s0));
        chk("R10", "last unchanged", 32'(last_flags), 32'(l0));
    endtask

    task automatic t_sync_branch();
        logic [4:0] s0;
        set_mode(10'b00_00_00_00_00);
        for (int i = 0; i < 4; i++) do_issue(32'h400 + 32'(4 * i));
        chk("R7", "full stalls", 32'(issue_ready), 0);
        sync_req = 1'b1; br_req = 1'b1; br_sel = 3'd2;
        #1;
        chk("R8", "pc_hold busy", 32'(pc_hold), 1);
        chk("R9", "br_wait busy", 32'(br_wait), 1);
        chk("R9", "br_taken busy", 32'(br_taken), 0);
        s0 = sticky_flags;
        do_cmpl(5'b00000);
        do_cmpl(5'b00000);
        do_cmpl(5'b00000);
        chk("R8", "sync leaves flags", 32'(sticky_flags), 32'(s0));
        do_cmpl(5'b00100);
        #1;
        chk("R8", "pc_hold idle", 32'(pc_hold), 0);
        chk("R9", "br_wait idle", 32'(br_wait), 0);
        chk("R9", "taken on overflow", 32'(br_taken), 1);
        br_sel = 3'd0;
        #1;
        chk("R9", "not taken on inexact", 32'(br_taken), 0);
        sync_req = 1'b0; br_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ctl_wr_en = 0; ctl_wr_mode = '0; sticky_wr_en = 0;
        sticky_wr_data = '0; issue_valid = 0; issue_pc = '0; cmpl_valid = 0;
        cmpl_flags = '0; sync_req = 0; br_req = 0; br_sel = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_nonstop();
        t_sticky_write();
        t_imprecise();
        t_precise();
        t_mixed();
        t_spurious();
        t_sync_branch();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule